// File: doc/BRIEF.md
# Byte-Lane Write Mask Generator

This block sits between the synchronous control pins of a 32-bit memory with four byte lanes and the array's write port. On every rising clock edge it captures the global write strobe, the common byte write strobe, the four per-lane selects and the three chip enables. It then produces a registered four-bit lane mask and a write-valid strobe, one clock later. Bit 0 of the mask is lane A, which covers data bits 7:0. Bit 3 is lane D, which covers data bits 31:24.

A global write stores all four lanes. A byte write stores only the lanes whose select is low. Nothing is written unless the device is selected by its mixed-polarity enable triple.

The array model consumes the mask and the strobe. It commits each enabled byte of the write data, which is held stable while the strobe is high.

Top module: `lane_wmask_gen`

## Requirements
- R1: While `rst_n` is low, `wr_valid` is 0 and `wr_mask` is 4'b0000.
- R2: With the device selected and `gwr_n` low at a sampling edge, `wr_mask` becomes 4'b1111 whatever `bwr_n` and `lane_n` are.
- R3: With the device selected, `gwr_n` high and `bwr_n` low, `wr_mask[i]` is 1 exactly when `lane_n[i]` was low (bit 0 = lane A, bits 7:0; bit 3 = lane D, bits 31:24).
- R4: With the device selected and both `gwr_n` and `bwr_n` high, `wr_mask` is 4'b0000 and `wr_valid` is 0 for any `lane_n`.
- R5: The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other combination forces `wr_mask` to 0 and `wr_valid` to 0, even with write strobes asserted.
- R6: Controls sampled at rising edge N appear on the outputs after rising edge N+1 and stay there until edge N+2. Back-to-back samples give back-to-back results.
- R7: `wr_valid` is 1 exactly when `wr_mask` has at least one bit set. A byte write with all lane selects high therefore produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Common byte write strobe, active low |
| lane_n | input | 4 | Per-lane selects, active low, bit 0 = lane A |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| wr_valid | output | 1 | Write strobe for the array |
| wr_mask | output | 4 | Registered byte-lane write mask |

## Verification
Two rules can apply in the same cycle: the global write override and the byte write path. Vectors drive `gwr_n` and `bwr_n` low together with a sparse `lane_n`, and a full mask is the only accepted result. Enable qualification can also meet a write. Strobes are asserted while each of the three enables is moved off its true level in turn, and the outputs are judged two edges later, along with the contents of the bench register file.

// File: rtl/lane_wmask_pkg.sv
package lane_wmask_pkg;
  localparam int unsigned LANES     = 4;
  localparam int unsigned LANE_BITS = 8;
  localparam int unsigned DATA_W    = LANES * LANE_BITS;

  typedef logic [LANES-1:0] mask_t;

  typedef struct packed {
    logic  gwr_n;
    logic  bwr_n;
    mask_t lane_n;
    logic  ce1_n;
    logic  ce2;
    logic  ce3_n;
  } ctrl_t;

  function automatic logic chip_selected(input logic e1_n, input logic e2, input logic e3_n);
    return (!e1_n) && e2 && (!e3_n);
  endfunction

  function automatic mask_t lane_mask(input logic sel, input logic g_n,
                                      input logic b_n, input mask_t l_n);
    mask_t m;
    m = '0;
    if (sel) begin
      if (!g_n)      m = '1;
      else if (!b_n) m = ~l_n;
    end
    return m;
  endfunction
endpackage

// File: rtl/lane_wmask_sample.sv
module lane_wmask_sample
  import lane_wmask_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t ctrl_d,
  output ctrl_t ctrl_q
);
  localparam ctrl_t IDLE = '{gwr_n: 1'b1, bwr_n: 1'b1, lane_n: '1,
                             ce1_n: 1'b1, ce2: 1'b0, ce3_n: 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= IDLE;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/lane_wmask_decode.sv
module lane_wmask_decode
  import lane_wmask_pkg::*;
(
  input  ctrl_t ctrl,
  output logic  sel,
  output mask_t mask
);
  always_comb begin
    sel  = chip_selected(ctrl.ce1_n, ctrl.ce2, ctrl.ce3_n);
    mask = lane_mask(sel, ctrl.gwr_n, ctrl.bwr_n, ctrl.lane_n);
  end
endmodule

// File: rtl/lane_wmask_outreg.sv
module lane_wmask_outreg
  import lane_wmask_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  mask_t mask_d,
  output logic  valid_q,
  output mask_t mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
    end else begin
      valid_q <= |mask_d;
      mask_q  <= mask_d;
    end
  end
endmodule

// File: rtl/lane_wmask_gen.sv
module lane_wmask_gen
  import lane_wmask_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gwr_n,
  input  logic       bwr_n,
  input  logic [3:0] lane_n,
  input  logic       ce1_n,
  input  logic       ce2,
  input  logic       ce3_n,
  output logic       wr_valid,
  output logic [3:0] wr_mask
);
  ctrl_t ctrl_in;
  ctrl_t ctrl_s;
  logic  sel_s;
  mask_t mask_s;

  assign ctrl_in = '{gwr_n: gwr_n, bwr_n: bwr_n, lane_n: lane_n,
                     ce1_n: ce1_n, ce2: ce2, ce3_n: ce3_n};

  lane_wmask_sample u_sample (
    .clk(clk), .rst_n(rst_n), .ctrl_d(ctrl_in), .ctrl_q(ctrl_s)
  );

  lane_wmask_decode u_decode (
    .ctrl(ctrl_s), .sel(sel_s), .mask(mask_s)
  );

  lane_wmask_outreg u_out (
    .clk(clk), .rst_n(rst_n), .mask_d(mask_s),
    .valid_q(wr_valid), .mask_q(wr_mask)
  );
endmodule

// File: rtl/lane_wmask_checker.sv
module lane_wmask_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       gwr_n,
  input logic       bwr_n,
  input logic [3:0] lane_n,
  input logic       ce1_n,
  input logic       ce2,
  input logic       ce3_n,
  input logic       wr_valid,
  input logic [3:0] wr_mask
);
  logic [1:0] warm;
  logic       on;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         warm <= 2'd0;
    else if (warm != 3) warm <= warm + 2'd1;
  end
  assign on = (warm >= 2);

  wire cs_ok = (ce1_n == 1'b0) && (ce2 == 1'b1) && (ce3_n == 1'b0);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!wr_valid && wr_mask == 4'h0));

  p_global_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (on && $past(cs_ok, 2) && !$past(gwr_n, 2)) |-> wr_mask == 4'hF);

  p_byte_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (on && $past(cs_ok, 2) && $past(gwr_n, 2) && !$past(bwr_n, 2))
      |-> wr_mask == ~$past(lane_n, 2));

  p_no_strobe_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (on && $past(gwr_n, 2) && $past(bwr_n, 2)) |-> (!wr_valid && wr_mask == 4'h0));

  p_deselect_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !$past(cs_ok, 2)) |-> (!wr_valid && wr_mask == 4'h0));

  p_valid_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid == ($countones(wr_mask) != 0));
endmodule

bind lane_wmask_gen lane_wmask_checker u_chk (
  .clk(clk), .rst_n(rst_n), .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_n(lane_n),
  .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .wr_valid(wr_valid), .wr_mask(wr_mask)
);

// File: tb/sim_lane_wmask_gen.sv
module sim_lane_wmask_gen;
  logic clk = 1'b0;
  logic rst_n;
  logic gwr_n, bwr_n, ce1_n, ce2, ce3_n;
  logic [3:0] lane_n;
  logic wr_valid;
  logic [3:0] wr_mask;
  logic [31:0] wdata;
  logic [31:0] mem;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lane_wmask_gen u0 (
    .clk(clk), .rst_n(rst_n), .gwr_n(gwr_n), .bwr_n(bwr_n), .lane_n(lane_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .wr_valid(wr_valid), .wr_mask(wr_mask)
  );

  // register-file model of the array
  always @(posedge clk) begin
    if (wr_valid)
      for (int i = 0; i < 4; i++)
        if (wr_mask[i]) mem[i*8 +: 8] <= wdata[i*8 +: 8];
  end

  // {gwr_n, bwr_n, lane_n[3:0], ce1_n, ce2, ce3_n, expected mask[3:0]}
  localparam int NV = 11;
  localparam logic [12:0] VEC [NV] = '{
    13'b0_1_1111_0_1_0_1111,  // R2 global, no lanes
    13'b0_0_0101_0_1_0_1111,  // R2 global wins over byte write
    13'b1_0_1110_0_1_0_0001,  // R3 lane A
    13'b1_0_0111_0_1_0_1000,  // R3 lane D
    13'b1_0_1010_0_1_0_0101,  // R3 lanes A,C
    13'b1_0_0000_0_1_0_1111,  // R3 all lanes
    13'b1_0_1111_0_1_0_0000,  // R7 byte write, no lane
    13'b1_1_0000_0_1_0_0000,  // R4 no strobe
    13'b0_0_0000_1_1_0_0000,  // R5 ce1_n high
    13'b0_0_0000_0_0_0_0000,  // R5 ce2 low
    13'b0_0_0000_0_1_1_0000   // R5 ce3_n high
  };

  task automatic check(input string req, input logic [3:0] m_exp, input logic v_exp);
    checks++;
    if (wr_mask !== m_exp || wr_valid !== v_exp) begin
      errors++;
      $display("FAIL %s: mask=%b valid=%b expected mask=%b valid=%b",
               req, wr_mask, wr_valid, m_exp, v_exp);
    end
  endtask

  task automatic drive(input logic [12:0] v);
    {gwr_n, bwr_n, lane_n, ce1_n, ce2, ce3_n} = v[12:4];
  endtask

  localparam logic [12:0] IDLE_V = 13'b1_1_1111_0_1_0_0000;

  initial begin
    rst_n = 1'b0;
    wdata = 32'h0;
    mem   = 32'h0;
    drive(13'b0_0_0000_0_1_0_0000);
    repeat (3) @(negedge clk);
    check("R1 reset", 4'h0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    drive(IDLE_V);
    repeat (2) @(negedge clk);

    // vector table
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k]);
      @(negedge clk);
      drive(IDLE_V);
      @(negedge clk);
      check($sformatf("R2/R3/R4/R5/R7 vec%0d", k), VEC[k][3:0], VEC[k][3:0] != 0);
      @(negedge clk);
    end

    // R6 latency: nothing after one edge, result after two, gone after three
    drive(VEC[3]);
    @(negedge clk);
    drive(IDLE_V);
    check("R6 not yet", 4'h0, 1'b0);
    @(negedge clk);
    check("R6 arrives", 4'h8, 1'b1);
    @(negedge clk);
    check("R6 cleared", 4'h0, 1'b0);

    // R6 back-to-back samples
    drive(VEC[2]);
    @(negedge clk); drive(VEC[4]);
    @(negedge clk); drive(VEC[9]);
    check("R6 b2b 1", 4'h1, 1'b1);
    @(negedge clk); drive(IDLE_V);
    check("R6 b2b 2", 4'h5, 1'b1);
    @(negedge clk);
    check("R6 b2b 3", 4'h0, 1'b0);
    @(negedge clk);

    // register file: global write then lane B byte write (R2, R3)
    wdata = 32'h1122_3344;
    drive(13'b0_1_1111_0_1_0_0000);
    @(negedge clk); drive(IDLE_V);
    repeat (3) @(negedge clk);
    checks++;
    if (mem !== 32'h1122_3344) begin
      errors++;
      $display("FAIL R2 memory: got %h expected %h", mem, 32'h1122_3344);
    end
    wdata = 32'hAABB_CCDD;
    drive(13'b1_0_1101_0_1_0_0000);
    @(negedge clk); drive(IDLE_V);
    repeat (3) @(negedge clk);
    checks++;
    if (mem !== 32'h1122_CC44) begin
      errors++;
      $display("FAIL R3 memory: got %h expected %h", mem, 32'h1122_CC44);
    end

    // R5 deselected global write leaves memory untouched
    wdata = 32'hFFFF_FFFF;
    drive(13'b0_0_0000_0_1_1_0000);
    @(negedge clk); drive(IDLE_V);
    repeat (3) @(negedge clk);
    checks++;
    if (mem !== 32'h1122_CC44) begin
      errors++;
      $display("FAIL R5 memory: got %h expected %h", mem, 32'h1122_CC44);
    end

    // R1 reset in mid-write
    drive(VEC[0]);
    @(negedge clk);
    @(negedge clk) rst_n = 1'b0;
    #1 check("R1 mid reset", 4'h0, 1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule